// File: doc/BRIEF.md
# Superpriority Interrupt Mask Arbiter

This block sits beside a processor core and decides, every cycle, which of six pending interrupt classes the core should take, if any. The classes are a physical non-maskable interrupt, a virtual non-maskable interrupt, physical fast and normal interrupts, and virtual fast and normal interrupts. The block registers all of its request, state and control inputs once. From those registered values it forms the virtual NMI pending level and a global all-interrupt mask. It then qualifies each class against its own mask bit and its hypervisor routing, and grants the first qualified class in a fixed order.

The global mask applies only when the core is already running at the level that the interrupt targets. It gates every class, including the superpriority NMI, which ignores the ordinary I and F masks. Virtual classes are taken only when the hypervisor routing sends them to the guest. The result is a take strobe and an exception code that the core's exception-entry logic consumes. Vector generation and state writeback belong to that logic, not to this block. A parameter removes the NMI classes entirely for cores without the feature.

Top module: `sprio_irq_arbiter`

## Requirements
- R1: After reset, and while reset is held, `take` is low and `exc_id` is 0.
- R2: `take` and `exc_id` reflect the inputs sampled at the previous rising clock edge. All inputs are registered once and the decision is combinational from those registers.
- R3: The all-interrupt mask is zero unless three conditions hold together: the NMI feature is built in (`HAS_NMI`=1), `ctl_nmi_en` is 1, and `cur_lvl` equals `tgt_lvl`.
- R4: When the R3 conditions hold, the all-interrupt mask is 1 if `ps_allint` is 1, or if both `ctl_spint_en` and `ps_sp` are 1.
- R5: A pending physical NMI is taken whenever the all-interrupt mask is clear, whatever the values of `ps_i` and `ps_f`.
- R6: A physical IRQ needs `ps_i`=0 and a clear all-interrupt mask. A physical FIQ needs `ps_f`=0 and a clear all-interrupt mask.
- R7: A virtual NMI is refused when `hv_imo` and `hv_fmo` are both 0, or when `hv_tge` is 1. Otherwise it is taken when the all-interrupt mask is clear.
- R8: A virtual IRQ needs `hv_imo`=1, `hv_tge`=0, `ps_i`=0 and a clear all-interrupt mask. A virtual FIQ needs `hv_fmo`=1, `hv_tge`=0, `ps_f`=0 and a clear all-interrupt mask.
- R9: The virtual NMI is pending when `pend_vnmi` is 1, or when `hv_vi` and `hv_vinmi_en` are both 1.
- R10: Among qualified classes the grant follows the order physical NMI, virtual NMI, FIQ, IRQ, virtual FIQ, virtual IRQ, with the first listed winning.
- R11: Nothing is taken when `tgt_lvl` is lower than `cur_lvl`.
- R12: `exc_id` is 26 for physical NMI, 27 for virtual NMI, 6 for FIQ, 5 for IRQ, 15 for virtual FIQ and 14 for virtual IRQ. When nothing qualifies, `take` is 0 and `exc_id` is 0.
- R13: With `HAS_NMI`=0, neither NMI class is ever taken and `ps_allint` has no effect on the other classes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_nmi | input | 1 | Physical NMI request |
| pend_vnmi | input | 1 | External virtual NMI request line |
| pend_fiq | input | 1 | Physical FIQ request |
| pend_irq | input | 1 | Physical IRQ request |
| pend_vfiq | input | 1 | Virtual FIQ request |
| pend_virq | input | 1 | Virtual IRQ request |
| cur_lvl | input | LVL_W | Current exception level |
| tgt_lvl | input | LVL_W | Exception level the interrupts target |
| ps_i | input | 1 | IRQ mask state bit |
| ps_f | input | 1 | FIQ mask state bit |
| ps_allint | input | 1 | All-interrupt mask state bit |
| ps_sp | input | 1 | Stack-select state bit |
| ctl_nmi_en | input | 1 | NMI enable for the target level |
| ctl_spint_en | input | 1 | Stack-select based interrupt masking enable |
| hv_imo | input | 1 | Route IRQ class to hypervisor |
| hv_fmo | input | 1 | Route FIQ class to hypervisor |
| hv_tge | input | 1 | Trap general exceptions to hypervisor |
| hv_vi | input | 1 | Virtual IRQ injection bit |
| hv_vinmi_en | input | 1 | Makes the injected virtual IRQ a virtual NMI |
| take | output | 1 | An interrupt is taken this cycle |
| exc_id | output | ID_W | Exception code of the taken interrupt, 0 if none |

## Verification
Every result has a latency of one clock. An input set is applied on a falling edge, captured by the next rising edge, and the outputs are read at the falling edge that follows, before any other stimulus changes. The vector table, the random sweep against a reference priority function written in the bench, and the directed cases all keep to this one-edge spacing. The reset check samples at a falling edge while reset is held, after a rising edge has passed.

// File: rtl/sprio_arb_pkg.sv
package sprio_arb_pkg;

   localparam int NCLS = 6;

   // index order is grant priority, lowest index wins
   typedef enum logic [2:0] {
      CLS_NMI  = 3'd0,
      CLS_VNMI = 3'd1,
      CLS_FIQ  = 3'd2,
      CLS_IRQ  = 3'd3,
      CLS_VFIQ = 3'd4,
      CLS_VIRQ = 3'd5
   } cls_e;

   localparam int ID_NONE = 0;
   localparam int ID_IRQ  = 5;
   localparam int ID_FIQ  = 6;
   localparam int ID_VIRQ = 14;
   localparam int ID_VFIQ = 15;
   localparam int ID_NMI  = 26;
   localparam int ID_VNMI = 27;

   function automatic int cls_code(input int k);
      case (k)
         0:       return ID_NMI;
         1:       return ID_VNMI;
         2:       return ID_FIQ;
         3:       return ID_IRQ;
         4:       return ID_VFIQ;
         5:       return ID_VIRQ;
         default: return ID_NONE;
      endcase
   endfunction

   function automatic bit cls_is_nmi(input int k);
      return (k == 0) || (k == 1);
   endfunction

   function automatic bit cls_is_virt(input int k);
      return (k == 1) || (k == 4) || (k == 5);
   endfunction

   function automatic bit cls_uses_f(input int k);
      return (k == 2) || (k == 4);
   endfunction

   function automatic bit cls_uses_i(input int k);
      return (k == 3) || (k == 5);
   endfunction

   typedef struct packed {
      logic       allint;
      logic       sp;
      logic       i;
      logic       f;
      logic       nmi_en;
      logic       spint_en;
      logic       imo;
      logic       fmo;
      logic       tge;
      logic       vi;
      logic       vinmi_en;
   } ctl_t;

endpackage

// File: rtl/sprio_mask_gen.sv
module sprio_mask_gen
   import sprio_arb_pkg::*;
#(
   parameter int LVL_W   = 2,
   parameter bit HAS_NMI = 1'b1
) (
   input  logic [LVL_W-1:0] cur_lvl,
   input  logic [LVL_W-1:0] tgt_lvl,
   input  ctl_t             ctl,
   input  logic             vnmi_line,
   output logic             all_mask,
   output logic             vnmi_lvl
);

   logic same_lvl;
   assign same_lvl = (cur_lvl == tgt_lvl);

   generate
      if (HAS_NMI) begin : g_nmi
         always_comb begin
            all_mask = 1'b0;
            if (ctl.nmi_en && same_lvl)
               all_mask = ctl.allint || (ctl.spint_en && ctl.sp);
         end
         assign vnmi_lvl = vnmi_line || (ctl.vi && ctl.vinmi_en);
      end else begin : g_no_nmi
         assign all_mask = 1'b0;
         assign vnmi_lvl = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/sprio_qualify.sv
module sprio_qualify
   import sprio_arb_pkg::*;
#(
   parameter int LVL_W   = 2,
   parameter bit HAS_NMI = 1'b1
) (
   input  logic [NCLS-1:0]  pend,
   input  logic [LVL_W-1:0] cur_lvl,
   input  logic [LVL_W-1:0] tgt_lvl,
   input  ctl_t             ctl,
   input  logic             all_mask,
   output logic [NCLS-1:0]  ok
);

   logic lvl_ok;
   assign lvl_ok = (tgt_lvl >= cur_lvl);

   generate
      for (genvar k = 0; k < NCLS; k++) begin : g_cls
         logic route_ok;
         logic own_mask;
         if (cls_is_nmi(k) && !HAS_NMI) begin : g_absent
            assign route_ok = 1'b0;
         end else if (k == int'(CLS_VNMI)) begin : g_vnmi
            assign route_ok = (ctl.imo || ctl.fmo) && !ctl.tge;
         end else if (cls_is_virt(k) && cls_uses_f(k)) begin : g_vf
            assign route_ok = ctl.fmo && !ctl.tge;
         end else if (cls_is_virt(k)) begin : g_vi
            assign route_ok = ctl.imo && !ctl.tge;
         end else begin : g_phys
            assign route_ok = 1'b1;
         end

         if (cls_uses_f(k)) begin : g_mf
            assign own_mask = ctl.f;
         end else if (cls_uses_i(k)) begin : g_mi
            assign own_mask = ctl.i;
         end else begin : g_mnone
            assign own_mask = 1'b0;
         end

         assign ok[k] = pend[k] && lvl_ok && route_ok && !own_mask && !all_mask;
      end
   endgenerate

endmodule

// File: rtl/sprio_pick.sv
module sprio_pick
   import sprio_arb_pkg::*;
#(
   parameter int ID_W = 7
) (
   input  logic [NCLS-1:0] ok,
   output logic [NCLS-1:0] grant,
   output logic            take,
   output logic [ID_W-1:0] exc_id
);

   generate
      for (genvar k = 0; k < NCLS; k++) begin : g_pri
         if (k == 0) begin : g_top
            assign grant[k] = ok[k];
         end else begin : g_rest
            assign grant[k] = ok[k] && !(|ok[k-1:0]);
         end
      end
   endgenerate

   always_comb begin
      exc_id = '0;
      for (int k = 0; k < NCLS; k++)
         if (grant[k]) exc_id = exc_id | ID_W'(cls_code(k));
   end

   assign take = |grant;

endmodule

// File: rtl/sprio_irq_arbiter.sv
module sprio_irq_arbiter
   import sprio_arb_pkg::*;
#(
   parameter int LVL_W   = 2,
   parameter int ID_W    = 7,
   parameter bit HAS_NMI = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pend_nmi,
   input  logic             pend_vnmi,
   input  logic             pend_fiq,
   input  logic             pend_irq,
   input  logic             pend_vfiq,
   input  logic             pend_virq,
   input  logic [LVL_W-1:0] cur_lvl,
   input  logic [LVL_W-1:0] tgt_lvl,
   input  logic             ps_i,
   input  logic             ps_f,
   input  logic             ps_allint,
   input  logic             ps_sp,
   input  logic             ctl_nmi_en,
   input  logic             ctl_spint_en,
   input  logic             hv_imo,
   input  logic             hv_fmo,
   input  logic             hv_tge,
   input  logic             hv_vi,
   input  logic             hv_vinmi_en,
   output logic             take,
   output logic [ID_W-1:0]  exc_id
);

   localparam int ID_MAX = ID_VNMI;

   generate
      if (ID_W < $clog2(ID_MAX + 1)) begin : g_bad_id
         $error("sprio_irq_arbiter: ID_W too narrow for exception codes");
      end
      if (LVL_W < 1) begin : g_bad_lvl
         $error("sprio_irq_arbiter: LVL_W must be at least 1");
      end
   endgenerate

   // input capture stage
   logic [NCLS-1:0]  pend_q;
   logic [LVL_W-1:0] cur_q, tgt_q;
   ctl_t             ctl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
         cur_q  <= '0;
         tgt_q  <= '0;
         ctl_q  <= '0;
      end else begin
         pend_q[CLS_NMI]  <= pend_nmi;
         pend_q[CLS_VNMI] <= pend_vnmi;
         pend_q[CLS_FIQ]  <= pend_fiq;
         pend_q[CLS_IRQ]  <= pend_irq;
         pend_q[CLS_VFIQ] <= pend_vfiq;
         pend_q[CLS_VIRQ] <= pend_virq;
         cur_q            <= cur_lvl;
         tgt_q            <= tgt_lvl;
         ctl_q            <= '{allint:   ps_allint,    sp:  ps_sp,
                               i:        ps_i,         f:   ps_f,
                               nmi_en:   ctl_nmi_en,   spint_en: ctl_spint_en,
                               imo:      hv_imo,       fmo: hv_fmo,
                               tge:      hv_tge,       vi:  hv_vi,
                               vinmi_en: hv_vinmi_en};
      end
   end

   logic            all_mask, vnmi_lvl;
   logic [NCLS-1:0] pend_eff, ok, grant;

   sprio_mask_gen #(.LVL_W(LVL_W), .HAS_NMI(HAS_NMI)) u_mask (
      .cur_lvl   (cur_q),
      .tgt_lvl   (tgt_q),
      .ctl       (ctl_q),
      .vnmi_line (pend_q[CLS_VNMI]),
      .all_mask  (all_mask),
      .vnmi_lvl  (vnmi_lvl)
   );

   always_comb begin
      pend_eff           = pend_q;
      pend_eff[CLS_VNMI] = vnmi_lvl;
   end

   sprio_qualify #(.LVL_W(LVL_W), .HAS_NMI(HAS_NMI)) u_qual (
      .pend     (pend_eff),
      .cur_lvl  (cur_q),
      .tgt_lvl  (tgt_q),
      .ctl      (ctl_q),
      .all_mask (all_mask),
      .ok       (ok)
   );

   sprio_pick #(.ID_W(ID_W)) u_pick (
      .ok     (ok),
      .grant  (grant),
      .take   (take),
      .exc_id (exc_id)
   );

   // checks next to the decision path
   p_onehot_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   p_idle_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !take |-> (exc_id == '0));

   p_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (tgt_q >= cur_q));

   p_global_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> !all_mask);

   p_irq_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (take && exc_id == ID_W'(ID_IRQ)) |-> !ctl_q.i);

   p_vnmi_route_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (take && exc_id == ID_W'(ID_VNMI)) |-> (!ctl_q.tge && (ctl_q.imo || ctl_q.fmo)));

   p_virt_route_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (take && exc_id == ID_W'(ID_VIRQ)) |-> (ctl_q.imo && !ctl_q.tge));

   p_nmi_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (take && exc_id != ID_W'(ID_NMI)) |-> !ok[CLS_NMI]);

   p_no_feature_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !HAS_NMI |-> (exc_id != ID_W'(ID_NMI) && exc_id != ID_W'(ID_VNMI)));

endmodule

// File: tb/sprio_irq_arbiter_tb.sv
module sprio_irq_arbiter_tb;

   // stimulus word: {nmi,vnmi,fiq,irq,vfiq,virq, cur[1:0], tgt[1:0],
   //                 i,f,allint,sp, nmi_en,spint_en, imo,fmo,tge,vi,vinmi}
   localparam int SW = 21;
   localparam int NV = 18;

   localparam logic [SW+6:0] VEC [NV] = '{
      {6'b111111, 2'd1, 2'd1, 4'b0000, 2'b10, 5'b00000, 7'd26}, // R10 all pending
      {6'b100000, 2'd1, 2'd1, 4'b1100, 2'b10, 5'b00000, 7'd26}, // R5 I,F ignored
      {6'b100000, 2'd1, 2'd1, 4'b0010, 2'b10, 5'b00000, 7'd0 }, // R4 allint masks
      {6'b100000, 2'd1, 2'd1, 4'b0010, 2'b00, 5'b00000, 7'd26}, // R3 nmi_en off
      {6'b100000, 2'd1, 2'd2, 4'b0010, 2'b10, 5'b00000, 7'd26}, // R3 levels differ
      {6'b100100, 2'd1, 2'd1, 4'b0001, 2'b11, 5'b00000, 7'd0 }, // R4 sp masks
      {6'b001100, 2'd0, 2'd1, 4'b0000, 2'b00, 5'b00000, 7'd6 }, // R10 FIQ over IRQ
      {6'b001100, 2'd0, 2'd1, 4'b0100, 2'b00, 5'b00000, 7'd5 }, // R6 F masks FIQ
      {6'b010000, 2'd1, 2'd1, 4'b0000, 2'b10, 5'b00000, 7'd0 }, // R7 no routing
      {6'b010000, 2'd1, 2'd1, 4'b0000, 2'b10, 5'b01000, 7'd27}, // R7 via FMO
      {6'b010000, 2'd1, 2'd1, 4'b0000, 2'b10, 5'b10100, 7'd0 }, // R7 TGE refuses
      {6'b000000, 2'd1, 2'd1, 4'b0000, 2'b10, 5'b10011, 7'd27}, // R9 injected
      {6'b000000, 2'd1, 2'd1, 4'b0000, 2'b10, 5'b10010, 7'd0 }, // R9 vinmi off
      {6'b000011, 2'd1, 2'd1, 4'b0000, 2'b00, 5'b10000, 7'd14}, // R8 VIRQ only routed
      {6'b000011, 2'd1, 2'd1, 4'b0000, 2'b00, 5'b11000, 7'd15}, // R10 VFIQ over VIRQ
      {6'b000010, 2'd1, 2'd1, 4'b0100, 2'b00, 5'b01000, 7'd0 }, // R8 F masks VFIQ
      {6'b000100, 2'd2, 2'd1, 4'b0000, 2'b00, 5'b00000, 7'd0 }, // R11 lower target
      {6'b000000, 2'd1, 2'd1, 4'b0000, 2'b00, 5'b00000, 7'd0 }  // R12 idle
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [SW-1:0] stim = '0;
   logic take, take_nf;
   logic [6:0] exc_id, exc_id_nf;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   sprio_irq_arbiter u_dut (
      .clk(clk), .rst_n(rst_n),
      .pend_nmi(stim[20]), .pend_vnmi(stim[19]), .pend_fiq(stim[18]),
      .pend_irq(stim[17]), .pend_vfiq(stim[16]), .pend_virq(stim[15]),
      .cur_lvl(stim[14:13]), .tgt_lvl(stim[12:11]),
      .ps_i(stim[10]), .ps_f(stim[9]), .ps_allint(stim[8]), .ps_sp(stim[7]),
      .ctl_nmi_en(stim[6]), .ctl_spint_en(stim[5]),
      .hv_imo(stim[4]), .hv_fmo(stim[3]), .hv_tge(stim[2]),
      .hv_vi(stim[1]), .hv_vinmi_en(stim[0]),
      .take(take), .exc_id(exc_id));

   sprio_irq_arbiter #(.HAS_NMI(1'b0)) u_dut_nofeat (
      .clk(clk), .rst_n(rst_n),
      .pend_nmi(stim[20]), .pend_vnmi(stim[19]), .pend_fiq(stim[18]),
      .pend_irq(stim[17]), .pend_vfiq(stim[16]), .pend_virq(stim[15]),
      .cur_lvl(stim[14:13]), .tgt_lvl(stim[12:11]),
      .ps_i(stim[10]), .ps_f(stim[9]), .ps_allint(stim[8]), .ps_sp(stim[7]),
      .ctl_nmi_en(stim[6]), .ctl_spint_en(stim[5]),
      .hv_imo(stim[4]), .hv_fmo(stim[3]), .hv_tge(stim[2]),
      .hv_vi(stim[1]), .hv_vinmi_en(stim[0]),
      .take(take_nf), .exc_id(exc_id_nf));

   // reference decision written from the requirements
   function automatic logic [6:0] ref_id(input logic [SW-1:0] s, input bit feat);
      logic nmi, vnmi, fiq, irq, vfiq, virq, i, f, al, sp, ne, se, imo, fmo, tge, vi, vn;
      logic [1:0] cur, tgt;
      logic gm;
      {nmi, vnmi, fiq, irq, vfiq, virq} = s[20:15];
      cur = s[14:13];
      tgt = s[12:11];
      {i, f, al, sp, ne, se, imo, fmo, tge, vi, vn} = s[10:0];
      if (tgt < cur) return 7'd0;
      gm = feat && ne && (cur == tgt) && (al || (se && sp));
      if (gm) return 7'd0;
      if (feat && nmi) return 7'd26;
      if (feat && (vnmi || (vi && vn)) && (imo || fmo) && !tge) return 7'd27;
      if (fiq && !f) return 7'd6;
      if (irq && !i) return 7'd5;
      if (vfiq && fmo && !tge && !f) return 7'd15;
      if (virq && imo && !tge && !i) return 7'd14;
      return 7'd0;
   endfunction

   task automatic check(input string req, input logic got_take, input logic [6:0] got_id,
                        input logic [6:0] exp_id);
      checks++;
      if (got_take !== (exp_id != 0) || got_id !== exp_id) begin
         errors++;
         $display("FAIL %s: take=%0b id=%0d expected take=%0b id=%0d",
                  req, got_take, got_id, (exp_id != 0), exp_id);
      end
   endtask

   // apply on a falling edge, result is due at the next falling edge
   task automatic apply(input logic [SW-1:0] s);
      stim = s;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset", take, exc_id, 7'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", take, exc_id, 7'd0);

      for (int n = 0; n < NV; n++) begin
         apply(VEC[n][SW+6:7]);
         check($sformatf("R2 vector %0d", n), take, exc_id, VEC[n][6:0]);
      end

      // R13: feature absent, NMI classes drop out and allint is inert
      apply({6'b111111, 2'd1, 2'd1, 4'b0000, 2'b10, 5'b00000});
      check("R13 no feature order", take_nf, exc_id_nf, 7'd6);
      apply({6'b100100, 2'd1, 2'd1, 4'b0010, 2'b10, 5'b10011});
      check("R13 allint inert", take_nf, exc_id_nf, 7'd5);

      // R2 latency: output must still show the previous decision before the edge
      stim = {6'b000000, 2'd1, 2'd1, 4'b0000, 2'b00, 5'b00000};
      @(posedge clk);
      @(negedge clk);
      stim = {6'b100000, 2'd1, 2'd1, 4'b0000, 2'b00, 5'b00000};
      #2;
      check("R2 before edge", take, exc_id, 7'd0);
      @(negedge clk);
      check("R2 after edge", take, exc_id, 7'd26);

      // R10 R12 random sweep against the reference
      for (int n = 0; n < 3000; n++) begin
         logic [SW-1:0] s;
         s = SW'($urandom);
         apply(s);
         check("R10 random", take, exc_id, ref_id(s, 1'b1));
         check("R13 random", take_nf, exc_id_nf, ref_id(s, 1'b0));
      end

      // R1 reset mid-run clears the decision
      stim = {6'b111111, 2'd1, 2'd1, 4'b0000, 2'b00, 5'b00000};
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 reset held", take, exc_id, 7'd0);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule